// File: doc/BRIEF.md
# Serial Configuration Bitstream ROM

This block is a synthesizable model of a read-only memory that hands a stored configuration bitstream to a loading device, one bit per serial clock. A single bit address counter selects the bit that is currently presented. The counter moves forward on each rising clock edge while the part is selected and released from reset. It parks at the last address instead of wrapping. The stored pattern is generated inside the RTL from parameters, so no memory file is needed.

Two controls gate the block. The first is a combined reset/output-enable pin whose active level is chosen by a parameter. The second is an active-low chip enable. When reset is active, the counter is forced to zero at once and the output floats. When the chip enable is inactive, the counter freezes, the output floats and a standby flag rises. The high-impedance state is shown by a separate drive-enable output, and the data bit is forced low whenever that drive-enable is low.

A loader that never pulses reset between loads picks up where the previous load stopped. This makes it possible to store several images back to back in one device.

Top module: `cfg_stream_rom`

## Requirements
- R1: `drive_o` is 1 exactly when chip enable is active (`ce_n_i`=0) and reset is inactive; whenever `drive_o` is 0, `data_o` is 0.
- R2: While reset is active, the address is zero immediately, without waiting for a clock edge, whatever `ce_n_i` is. After release, `data_o` shows the bit at address 0 before any clock edge.
- R3: With `RST_ACTIVE_HIGH`=1, `rst_oe_i`=1 is reset and 0 is output enable. With `RST_ACTIVE_HIGH`=0, the levels swap: `rst_oe_i`=0 is reset.
- R4: On each rising edge of `clk_i` with chip enable active, reset inactive and the address below terminal count, the address rises by one, and `data_o` then shows the bit of the new address.
- R5: While `ce_n_i`=1, rising edges leave the address unchanged, `standby_o` is 1 and `drive_o` is 0. `standby_o` is 0 while `ce_n_i`=0.
- R6: Terminal count is `DEPTH`-1. Once there, the address stays there on further edges until reset. `at_tc_o` is 1 exactly while the address equals terminal count.
- R7: The stored bit at address a is the XOR-reduction of (a AND `MASK`), XORed with `INVERT`. The defaults are `DEPTH`=64, `MASK`=45 and `INVERT`=1.
- R8: Without a reset between loads, a load that follows a chip-enable off period continues from the address the previous load left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial clock from the loader |
| rst_oe_i | input | 1 | Combined reset / output enable; active level set by RST_ACTIVE_HIGH |
| ce_n_i | input | 1 | Chip enable, active low |
| data_o | output | 1 | Serial data bit, 0 when not driven |
| drive_o | output | 1 | 1 when the data line is driven; 0 models high impedance |
| standby_o | output | 1 | 1 while chip enable is inactive |
| at_tc_o | output | 1 | 1 while the address sits at terminal count |

## Verification
The hardest condition to reach is the clamp at terminal count, followed by a second load with no reset in between. The stimulus walks the address through all 64 positions, parks it for several extra edges, drops chip enable and then raises it again. Only after that does it pulse reset, to confirm the restart at zero. A second instance with active-low reset polarity and a smaller depth exercises the swapped pin meaning and a different stored pattern.

// File: rtl/cfg_stream_rom.sv
module cfg_stream_rom #(
  parameter int unsigned DEPTH           = 64,
  parameter bit          RST_ACTIVE_HIGH = 1'b1,
  parameter int unsigned MASK            = 45,
  parameter bit          INVERT          = 1'b1
) (
  input  logic clk_i,
  input  logic rst_oe_i,
  input  logic ce_n_i,
  output logic data_o,
  output logic drive_o,
  output logic standby_o,
  output logic at_tc_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] TC_ADDR = AW'(DEPTH - 1);
  localparam logic [AW-1:0] MASK_V  = AW'(MASK);

  logic             rst_act;
  logic             ce_act;
  logic [AW-1:0]    addr;
  logic [DEPTH-1:0] rom_bits;

  assign rst_act = RST_ACTIVE_HIGH ? rst_oe_i : ~rst_oe_i;
  assign ce_act  = ~ce_n_i;

  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    assign rom_bits[g] = (^(AW'(g) & MASK_V)) ^ INVERT;
  end

  always_ff @(posedge clk_i or posedge rst_act) begin
    if (rst_act)                      addr <= '0;
    else if (ce_act && addr != TC_ADDR) addr <= addr + 1'b1;
  end

  assign drive_o   = ce_act & ~rst_act;
  assign data_o    = drive_o & rom_bits[addr];
  assign standby_o = ~ce_act;
  assign at_tc_o   = (addr == TC_ADDR);
endmodule

// File: rtl/cfg_stream_rom_chk.sv
module cfg_stream_rom_chk #(
  parameter int unsigned AW = 6,
  parameter logic [AW-1:0] TC = '1
) (
  input logic          clk_i,
  input logic          rst_act,
  input logic          ce_n_i,
  input logic [AW-1:0] addr,
  input logic          drive_o,
  input logic          data_o,
  input logic          standby_o,
  input logic          at_tc_o
);
  always_comb begin
    p_float_low_r1: assert (drive_o || !data_o);
    p_standby_quiet_r5: assert (!standby_o || !drive_o);
  end

  p_reset_zero_r2: assert property (@(posedge clk_i)
    rst_act |-> (addr == '0 && !drive_o));

  p_advance_r4: assert property (@(posedge clk_i) disable iff (rst_act)
    (!ce_n_i && addr != TC) |=> (addr == $past(addr) + 1'b1));

  p_freeze_r5: assert property (@(posedge clk_i) disable iff (rst_act)
    ce_n_i |=> $stable(addr));

  p_clamp_r6: assert property (@(posedge clk_i) disable iff (rst_act)
    at_tc_o |=> (at_tc_o && addr == TC));
endmodule

bind cfg_stream_rom cfg_stream_rom_chk #(.AW(AW), .TC(TC_ADDR)) u_chk (
  .clk_i(clk_i), .rst_act(rst_act), .ce_n_i(ce_n_i), .addr(addr),
  .drive_o(drive_o), .data_o(data_o), .standby_o(standby_o), .at_tc_o(at_tc_o)
);

// File: tb/tb_cfg_stream_rom.sv
`timescale 1ns/1ps
module tb_cfg_stream_rom;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_oe, ce_n, data, drive, stby, tc;
  logic rst_lo, ce_n_lo, data_lo, drive_lo, stby_lo, tc_lo;

  cfg_stream_rom dut (
    .clk_i(clk), .rst_oe_i(rst_oe), .ce_n_i(ce_n),
    .data_o(data), .drive_o(drive), .standby_o(stby), .at_tc_o(tc));

  cfg_stream_rom #(.DEPTH(16), .RST_ACTIVE_HIGH(1'b0), .MASK(6), .INVERT(1'b0)) dut_lo (
    .clk_i(clk), .rst_oe_i(rst_lo), .ce_n_i(ce_n_lo),
    .data_o(data_lo), .drive_o(drive_lo), .standby_o(stby_lo), .at_tc_o(tc_lo));

  int checks = 0, fails = 0;
  bit done = 1'b0;

  function automatic bit ref_bit(int a, int m, bit inv);
    return (^(a & m)) ^ inv;
  endfunction

  task automatic chk(logic act, logic exp, string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  // row: {rst_oe, ce_n, cycles}
  localparam int NROW = 12;
  localparam logic [9:0] ROWS [NROW] = '{
    {1'b1, 1'b0, 8'd2},
    {1'b0, 1'b0, 8'd5},
    {1'b0, 1'b1, 8'd3},
    {1'b0, 1'b0, 8'd10},
    {1'b1, 1'b1, 8'd1},
    {1'b0, 1'b0, 8'd66},
    {1'b0, 1'b0, 8'd3},
    {1'b0, 1'b1, 8'd2},
    {1'b0, 1'b0, 8'd2},
    {1'b1, 1'b0, 8'd1},
    {1'b0, 1'b0, 8'd4},
    {1'b0, 1'b1, 8'd1}
  };

  int ma = 0;

  task automatic check_main(string ctx);
    bit r = rst_oe, c = ~ce_n;
    chk(drive, c & ~r, "R1 drive");
    chk(data, (c & ~r) ? ref_bit(ma, 45, 1'b1) : 1'b0, {"R7/R4 data ", ctx});
    chk(stby, ~c, "R5 standby");
    chk(tc, ma == 63, "R6 at_tc");
  endtask

  int la = 0;
  task automatic check_lo(string ctx);
    bit r = ~rst_lo, c = ~ce_n_lo;
    chk(drive_lo, c & ~r, {"R3 drive_lo ", ctx});
    chk(data_lo, (c & ~r) ? ref_bit(la, 6, 1'b0) : 1'b0, {"R3 data_lo ", ctx});
    chk(tc_lo, la == 15, "R6 at_tc_lo");
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_oe = 1'b1; ce_n = 1'b0; rst_lo = 1'b0; ce_n_lo = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    ma = 0;
    chk(drive, 1'b0, "R2 reset state drive");
    chk(tc, 1'b0, "R2 reset state at_tc");
    chk(drive_lo, 1'b0, "R3 low-polarity reset floats");

    for (int i = 0; i < NROW; i++) begin
      @(negedge clk);
      rst_oe = ROWS[i][9]; ce_n = ROWS[i][8];
      if (rst_oe) ma = 0;
      #1 check_main("apply R2");
      for (int k = 0; k < int'(ROWS[i][7:0]); k++) begin
        @(posedge clk);
        if (rst_oe) ma = 0;
        else if (!ce_n && ma != 63) ma++;
        #1 check_main("edge R4 R5 R6 R8");
      end
    end

    // R8: park at terminal count, CE off, CE on: still at terminal count, no restart
    @(negedge clk); rst_oe = 1'b0; ce_n = 1'b0;
    repeat (70) @(posedge clk);
    @(negedge clk); ce_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk); ce_n = 1'b0;
    #1 chk(tc, 1'b1, "R8 continue at last address");
    chk(data, ref_bit(63, 45, 1'b1), "R8 data at last address");

    // R2: asynchronous reset mid-cycle, then release before any edge
    @(negedge clk); rst_oe = 1'b1;
    #1 chk(drive, 1'b0, "R2 async reset floats");
    @(posedge clk); #1;
    rst_oe = 1'b0;
    #0.5 chk(data, ref_bit(0, 45, 1'b1), "R2 address zero after release");
    chk(tc, 1'b0, "R2 at_tc clear after reset");

    // R3: active-low polarity instance
    @(negedge clk); rst_lo = 1'b1; ce_n_lo = 1'b0; la = 0;
    #1 check_lo("released");
    for (int k = 0; k < 20; k++) begin
      @(posedge clk);
      if (la != 15) la++;
      #1 check_lo("count");
    end
    @(negedge clk); ce_n_lo = 1'b1;
    #1 chk(stby_lo, 1'b1, "R5 standby_lo");
    chk(drive_lo, 1'b0, "R5 drive_lo off");
    @(negedge clk); rst_lo = 1'b0; ce_n_lo = 1'b0; la = 0;
    #1 check_lo("reset low level");
    @(posedge clk); #1 check_lo("held in reset");
    @(negedge clk); rst_lo = 1'b1;
    #1 check_lo("restart");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule